// File: doc/BRIEF.md
# Bandwidth-Share Domain Arbiter

This block picks, on the address channel, one winner among up to ten masters that share one functional domain of a memory subsystem. Each master holds a bandwidth budget measured in data beats. The budget is reloaded from a programmable share at the start of every fixed-length window and drawn down by one for each data beat the master actually moves. Requests whose budget covers their burst are preferred, and among those the one with the most budget left wins. A master that has waited as long as its programmed latency limit jumps ahead of all budget ordering, so no master can starve.

The request side is a valid/ready handshake. A master raises its `req_valid` bit and holds it, together with its burst length, until it sees its `grant` bit. `grant` is the ready: a transfer completes in the cycle where a master's valid and grant bits are both high. A grant, once given, stays on that master until that handshake. The arbiter never withdraws a grant, and a master never drops a valid that has not yet been accepted. Per-master shares, latency limits, the arbitration mode and a read view of the live budgets sit behind a small register port with APB-style timing.

Top module: `bw_domain_arb`

## Requirements
- R1: `grant` is zero or one-hot. It only covers a master whose `req_valid` is high, and when it is non-zero `grant_idx` names the set bit.
- R2: A grant stays on its master until that master's handshake. In the cycle after the handshake, the same master does not hold the grant.
- R3: If no grant is held and any master requests, a grant is present in the next cycle.
- R4: Each `beat_done` pulse lowers that master's budget by one, and the budget stays at zero once it gets there. The budget can be read at register field 2.
- R5: Every 500 cycles after reset, each budget is reloaded from its share. A share written mid-window changes nothing until the next reload.
- R6: In budget mode, a request is funded when its budget is at least its beat count. `req_len` bits [4i+3:4i] hold beats minus one for master i. Funded requests beat unfunded ones, and within a class the larger budget wins.
- R7: Requests with equal rank are taken in round-robin order, starting after the last master granted. The first search after reset starts at master 0.
- R8: A requesting master whose wait count has reached its latency limit is urgent. Urgent masters outrank all others, and among urgent masters the lowest index wins.
- R9: The mode register is index 31, field 0, bit 0. It resets to 1, which selects budget mode. Writing 0 selects plain round-robin, and urgency still applies in that mode.
- R10: Register address bits [6:2] give the master index and bits [1:0] give the field: 0 is share, 1 is latency limit, 2 is budget. Shares reset to 50 and limits reset to 64. Accesses to an index at or above the master count are ignored on write and read as 0.
- R11: After reset, `grant` is 0 and `grant_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 10 | Address request valid, one bit per master |
| req_len | input | 40 | Burst beats minus one, four bits per master |
| grant | output | 10 | One-hot grant, serving as ready to each master |
| grant_idx | output | 4 | Index of the granted master, 0 when idle |
| beat_done | input | 10 | One pulse per accepted data beat, per master |
| psel | input | 1 | Register select |
| penable | input | 1 | Register access phase |
| pwrite | input | 1 | Register write when high |
| paddr | input | 7 | Register address |
| pwdata | input | 16 | Register write data |
| prdata | output | 16 | Register read data |

## Verification
The checker assumes that each master follows the handshake rules: valid stays high and the burst length stays stable from the time a request is raised until its grant is accepted. Under that assumption, "grant only to a requester" and "no re-grant right after a handshake" are real properties of the block and not vacuous ones. The bench honours this by raising requests as a set and dropping a master's valid only one cycle after it first sees its own grant. That is the cycle after the handshake edge. The bench applies beat pulses as single-cycle strobes and times budget reads with its own count of cycles since reset, so that no reload falls between a stimulus and the read that observes it.

// File: rtl/bwarb_pkg.sv
`timescale 1ns/1ps
package bwarb_pkg;
  localparam int LEN_W = 4;
  localparam int FLD_W = 2;

  typedef enum logic [FLD_W-1:0] {
    FLD_SHARE  = 2'd0,
    FLD_LAT    = 2'd1,
    FLD_CREDIT = 2'd2,
    FLD_SPARE  = 2'd3
  } fld_e;
endpackage

// File: rtl/bwarb_cfg.sv
`timescale 1ns/1ps
module bwarb_cfg
  import bwarb_pkg::*;
#(
  parameter int N         = 10,
  parameter int CRED_W    = 10,
  parameter int LAT_W     = 8,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16,
  parameter int SHARE_DEF = 50,
  parameter int LAT_DEF   = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         psel,
  input  logic                         penable,
  input  logic                         pwrite,
  input  logic [ADDR_W-1:0]            paddr,
  input  logic [DATA_W-1:0]            pwdata,
  output logic [DATA_W-1:0]            prdata,
  input  logic [N-1:0][CRED_W-1:0]     credit,
  output logic [N-1:0][CRED_W-1:0]     share,
  output logic [N-1:0][LAT_W-1:0]      max_lat,
  output logic                         credit_mode
);
  localparam int IDX_W = ADDR_W - FLD_W;
  localparam logic [IDX_W-1:0] MODE_IDX = '1;

  logic             wr_en;
  logic [IDX_W-1:0] idx;
  fld_e             fld;
  logic             idx_ok;
  logic             unused_wdata;

  assign wr_en        = psel & penable & pwrite;
  assign idx          = paddr[ADDR_W-1:FLD_W];
  assign fld          = fld_e'(paddr[FLD_W-1:0]);
  assign idx_ok       = (int'(idx) < N);
  assign unused_wdata = ^pwdata;

  // per-master share and latency limit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        share[i]   <= CRED_W'(SHARE_DEF);
        max_lat[i] <= LAT_W'(LAT_DEF);
      end
    end else if (wr_en) begin
      for (int i = 0; i < N; i++) begin
        if (idx == IDX_W'(i)) begin
          case (fld)
            FLD_SHARE: share[i]   <= pwdata[CRED_W-1:0];
            FLD_LAT:   max_lat[i] <= pwdata[LAT_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  // arbitration mode: 1 = budget ordering, 0 = plain rotation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_mode <= 1'b1;
    end else if (wr_en && idx == MODE_IDX && fld == FLD_SHARE) begin
      credit_mode <= pwdata[0];
    end
  end

  always_comb begin
    prdata = '0;
    if (idx == MODE_IDX && fld == FLD_SHARE) begin
      prdata = DATA_W'(credit_mode);
    end else if (idx_ok) begin
      case (fld)
        FLD_SHARE:  prdata = DATA_W'(share[idx]);
        FLD_LAT:    prdata = DATA_W'(max_lat[idx]);
        FLD_CREDIT: prdata = DATA_W'(credit[idx]);
        default:    prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/bwarb_credit.sv
`timescale 1ns/1ps
module bwarb_credit #(
  parameter int N         = 10,
  parameter int CRED_W    = 10,
  parameter int PERIOD    = 500,
  parameter int SHARE_DEF = 50
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0][CRED_W-1:0] share,
  input  logic [N-1:0]             beat_done,
  output logic [N-1:0][CRED_W-1:0] credit,
  output logic                     refill
);
  localparam int WIN_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [WIN_W-1:0]          wcnt;
  logic [N-1:0][CRED_W-1:0]  credit_nx;

  assign refill = (wcnt == WIN_W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) wcnt <= '0;
    else if (refill) wcnt <= '0;
    else wcnt <= wcnt + 1'b1;
  end

  // reload first, then charge this cycle's beat, saturating at zero
  always_comb begin
    for (int i = 0; i < N; i++) begin
      credit_nx[i] = refill ? share[i] : credit[i];
      if (beat_done[i] && credit_nx[i] != '0) begin
        credit_nx[i] = credit_nx[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) credit[i] <= CRED_W'(SHARE_DEF);
    end else begin
      credit <= credit_nx;
    end
  end
endmodule

// File: rtl/bwarb_wait.sv
`timescale 1ns/1ps
module bwarb_wait #(
  parameter int N     = 10,
  parameter int LAT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            req_valid,
  input  logic [N-1:0]            hs,
  input  logic [N-1:0][LAT_W-1:0] max_lat,
  output logic [N-1:0]            urgent
);
  logic [N-1:0][LAT_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!req_valid[i] || hs[i]) wcnt[i] <= '0;
        else if (wcnt[i] != '1) wcnt[i] <= wcnt[i] + 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      urgent[i] = req_valid[i] && (wcnt[i] >= max_lat[i]);
    end
  end
endmodule

// File: rtl/bwarb_pick.sv
`timescale 1ns/1ps
module bwarb_pick
  import bwarb_pkg::*;
#(
  parameter int N      = 10,
  parameter int CRED_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic [N-1:0]             cand,
  input  logic [N-1:0]             urgent,
  input  logic [N-1:0][CRED_W-1:0] credit,
  input  logic [N-1:0][LEN_W-1:0]  req_len,
  input  logic [IDX_W-1:0]         last,
  input  logic                     credit_mode,
  output logic                     win_valid,
  output logic [IDX_W-1:0]         win_idx
);
  logic [N-1:0] hot;
  assign hot = cand & urgent;

  always_comb begin
    int j;
    logic funded;
    logic [CRED_W:0] key;
    logic [CRED_W:0] best;
    j         = 0;
    funded    = 1'b0;
    key       = '0;
    best      = '0;
    win_valid = 1'b0;
    win_idx   = '0;
    if (|hot) begin
      // deadline path: lowest index among urgent requesters
      for (int i = N - 1; i >= 0; i--) begin
        if (hot[i]) begin
          win_valid = 1'b1;
          win_idx   = IDX_W'(i);
        end
      end
    end else begin
      // scan in rotation order after the last grantee; strict compare
      // keeps the earliest-in-rotation among equal keys
      for (int k = 0; k < N; k++) begin
        j = int'(last) + 1 + k;
        if (j >= N) j = j - N;
        funded = credit[j] > CRED_W'(req_len[j]);
        key    = credit_mode ? {funded, credit[j]} : '0;
        if (cand[j] && (!win_valid || key > best)) begin
          win_valid = 1'b1;
          win_idx   = IDX_W'(j);
          best      = key;
        end
      end
    end
  end
endmodule

// File: rtl/bw_domain_arb.sv
`timescale 1ns/1ps
module bw_domain_arb
  import bwarb_pkg::*;
#(
  parameter int N_MST         = 10,
  parameter int CRED_W        = 10,
  parameter int LAT_W         = 8,
  parameter int REFILL_PERIOD = 500,
  parameter int SHARE_DEF     = 50,
  parameter int LAT_DEF       = 64,
  parameter int ADDR_W        = 7,
  parameter int DATA_W        = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_MST-1:0]           req_valid,
  input  logic [N_MST*LEN_W-1:0]     req_len,
  output logic [N_MST-1:0]           grant,
  output logic [$clog2(N_MST)-1:0]   grant_idx,
  input  logic [N_MST-1:0]           beat_done,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [DATA_W-1:0]          pwdata,
  output logic [DATA_W-1:0]          prdata
);
  localparam int GI_W = $clog2(N_MST);

  logic [N_MST-1:0][LEN_W-1:0]  len_a;
  logic [N_MST-1:0][CRED_W-1:0] cred_w;
  logic [N_MST-1:0][CRED_W-1:0] share_w;
  logic [N_MST-1:0][LAT_W-1:0]  lat_w;
  logic                         mode_w;
  logic                         refill_w;
  logic [N_MST-1:0]             grant_q, hs, cand, urgent;
  logic [GI_W-1:0]              gidx_q, last_q, win_idx;
  logic                         win_valid, slot_free;

  assign len_a     = req_len;
  assign hs        = req_valid & grant_q;
  assign cand      = req_valid & ~hs;
  assign slot_free = (grant_q == '0) || (|hs);

  bwarb_cfg #(
    .N(N_MST), .CRED_W(CRED_W), .LAT_W(LAT_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .SHARE_DEF(SHARE_DEF), .LAT_DEF(LAT_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .credit(cred_w), .share(share_w), .max_lat(lat_w),
    .credit_mode(mode_w)
  );

  bwarb_credit #(
    .N(N_MST), .CRED_W(CRED_W), .PERIOD(REFILL_PERIOD),
    .SHARE_DEF(SHARE_DEF)
  ) u_credit (
    .clk(clk), .rst_n(rst_n), .share(share_w), .beat_done(beat_done),
    .credit(cred_w), .refill(refill_w)
  );

  bwarb_wait #(.N(N_MST), .LAT_W(LAT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hs(hs),
    .max_lat(lat_w), .urgent(urgent)
  );

  bwarb_pick #(.N(N_MST), .CRED_W(CRED_W), .IDX_W(GI_W)) u_pick (
    .cand(cand), .urgent(urgent), .credit(cred_w), .req_len(len_a),
    .last(last_q), .credit_mode(mode_w), .win_valid(win_valid),
    .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      gidx_q  <= '0;
      last_q  <= GI_W'(N_MST - 1);
    end else if (slot_free) begin
      if (win_valid) begin
        grant_q <= N_MST'(1) << win_idx;
        gidx_q  <= win_idx;
        last_q  <= win_idx;
      end else begin
        grant_q <= '0;
        gidx_q  <= '0;
      end
    end
  end

  assign grant     = grant_q;
  assign grant_idx = gidx_q;
endmodule

// File: rtl/bwarb_chk.sv
`timescale 1ns/1ps
module bwarb_chk #(
  parameter int N      = 10,
  parameter int CRED_W = 10,
  parameter int GI_W   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N-1:0]             req_valid,
  input logic [N-1:0]             grant,
  input logic [GI_W-1:0]          grant_idx,
  input logic [N-1:0]             beat_done,
  input logic [N-1:0][CRED_W-1:0] credit,
  input logic [N-1:0][CRED_W-1:0] share,
  input logic                     refill
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_to_requester_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0);

  p_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> grant[grant_idx]);

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & req_valid) != '0) |=> ((grant & $past(grant)) == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (grant & req_valid) == '0) |=> $stable(grant));

  p_prompt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req_valid != '0) |=> (grant != '0));

  for (genvar g = 0; g < N; g++) begin : g_cred
    p_charge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!refill && beat_done[g] && credit[g] != '0)
        |=> (credit[g] == $past(credit[g]) - 1'b1));

    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!refill && !beat_done[g]) |=> $stable(credit[g]));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (refill && !beat_done[g]) |=> (credit[g] == $past(share[g])));
  end
endmodule

bind bw_domain_arb bwarb_chk #(
  .N(N_MST), .CRED_W(CRED_W), .GI_W(GI_W)
) u_bwarb_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .grant(grant),
  .grant_idx(grant_idx), .beat_done(beat_done), .credit(cred_w),
  .share(share_w), .refill(refill_w)
);

// File: tb/bw_domain_arb_bench.sv
`timescale 1ns/1ps
module bw_domain_arb_bench;
  localparam int N      = 10;
  localparam int LW     = 4;
  localparam int AW     = 7;
  localparam int DW     = 16;
  localparam int PERIOD = 500;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  reqv = '0;
  logic [N-1:0]  beats = '0;
  logic [N*LW-1:0] lens = '0;
  logic [N-1:0]  grant;
  logic [3:0]    gidx;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bw_domain_arb u_bw_domain_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(reqv), .req_len(lens),
    .grant(grant), .grant_idx(gidx), .beat_done(beats),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apb_wr(int idx, int fld, int val);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
    paddr = AW'((idx << 2) | fld); pwdata = DW'(val);
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(int idx, int fld, output int val);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0;
    paddr = AW'((idx << 2) | fld);
    @(negedge clk);
    penable = 1'b1;
    val = int'(prdata);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic set_len(int m, int v);
    lens[m*LW +: LW] = LW'(v);
  endtask

  task automatic pulse_beats(int m, int n);
    repeat (n) begin
      @(negedge clk) beats[m] = 1'b1;
      @(negedge clk) beats[m] = 1'b0;
    end
  endtask

  // land just after a window reload that follows the call
  task automatic wait_refill();
    @(negedge clk);
    while (cyc % PERIOD != 250) @(negedge clk);
    while (cyc % PERIOD != 3) @(negedge clk);
  endtask

  // raise a set of requests, retire each on its grant, compare order
  task automatic contest(string tag, logic [N-1:0] mask, int n_exp, int exp[N]);
    logic [N-1:0] drop;
    int got[N];
    int cnt;
    bit first;
    for (int k = 0; k < N; k++) got[k] = -1;
    @(negedge clk);
    reqv = mask; drop = '0; cnt = 0; first = 1'b1;
    for (int t = 0; t < 4 * N + 8; t++) begin
      @(negedge clk);
      if (drop != '0) begin
        reqv = reqv & ~drop;
        drop = '0;
      end
      if (first) begin
        chk({tag, " R3 grant in next cycle"}, int'(grant != '0), 1);
        first = 1'b0;
      end
      if (grant != '0) begin
        chk({tag, " R1 one-hot"}, $countones(grant), 1);
        chk({tag, " R1 only requesters"}, int'((grant & ~reqv) == '0), 1);
        chk({tag, " R1 index matches"}, int'(grant[gidx]), 1);
        if (cnt < N) got[cnt] = int'(gidx);
        cnt++;
        drop = grant;
      end
      if (reqv == '0 && drop == '0) break;
    end
    chk({tag, " R2 released after handshake"}, int'(grant), 0);
    chk({tag, " grant count"}, cnt, n_exp);
    for (int k = 0; k < n_exp; k++) chk({tag, " order"}, got[k], exp[k]);
  endtask

  task automatic t_reset();
    int v;
    chk("R11 grant at reset", int'(grant), 0);
    chk("R11 index at reset", int'(gidx), 0);
    apb_rd(0, 0, v); chk("R10 share default", v, 50);
    apb_rd(0, 1, v); chk("R10 limit default", v, 64);
    apb_rd(0, 2, v); chk("R10 budget default", v, 50);
    apb_rd(31, 0, v); chk("R9 mode default", v, 1);
  endtask

  task automatic t_regs();
    int v;
    apb_wr(3, 0, 77); apb_rd(3, 0, v); chk("R10 share write", v, 77);
    apb_wr(3, 1, 9);  apb_rd(3, 1, v); chk("R10 limit write", v, 9);
    apb_wr(12, 0, 5); apb_rd(12, 0, v); chk("R10 out-of-range reads 0", v, 0);
    apb_rd(3, 0, v); chk("R10 neighbour untouched", v, 77);
    apb_wr(3, 0, 50); apb_wr(3, 1, 64);
  endtask

  task automatic t_single();
    int e[N] = '{6, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    contest("single", 10'(1 << 6), 1, e);
    chk("R11 index idle again", int'(gidx), 0);
  endtask

  task automatic t_credit();
    int v;
    wait_refill();
    pulse_beats(5, 3);
    apb_rd(5, 2, v); chk("R4 three beats charged", v, 47);
    apb_wr(6, 0, 2); apb_wr(5, 0, 20);
    apb_rd(5, 2, v); chk("R5 share waits for reload", v, 47);
    wait_refill();
    apb_rd(5, 2, v); chk("R5 reload to new share", v, 20);
    apb_rd(6, 2, v); chk("R5 reload small share", v, 2);
    pulse_beats(6, 4);
    apb_rd(6, 2, v); chk("R4 saturates at zero", v, 0);
    apb_wr(5, 0, 50); apb_wr(6, 0, 50);
  endtask

  task automatic t_funded();
    int e[N] = '{9, 7, 4, 1, 2, 0, 0, 0, 0, 0};
    apb_wr(4, 0, 30); apb_wr(7, 0, 40); apb_wr(2, 0, 10); apb_wr(1, 0, 8);
    set_len(2, 15);
    wait_refill();
    contest("R6 funded then budget", 10'((1 << 9) | (1 << 7) | (1 << 4) | (1 << 2) | (1 << 1)), 5, e);
  endtask

  task automatic t_tie();
    int e[N] = '{3, 5, 8, 0, 0, 0, 0, 0, 0, 0};
    contest("R7 equal budgets rotate", 10'((1 << 0) | (1 << 3) | (1 << 5) | (1 << 8)), 4, e);
  endtask

  task automatic t_urgent();
    int e[N] = '{9, 2, 4, 7, 0, 0, 0, 0, 0, 0};
    apb_wr(2, 1, 1); apb_wr(4, 1, 1);
    contest("R8 deadline promotion", 10'((1 << 2) | (1 << 4) | (1 << 7) | (1 << 9)), 4, e);
    apb_wr(2, 1, 64); apb_wr(4, 1, 64);
  endtask

  task automatic t_mode();
    int v;
    int e[N] = '{1, 2, 4, 7, 0, 0, 0, 0, 0, 0};
    apb_wr(31, 0, 0);
    apb_rd(31, 0, v); chk("R9 mode cleared", v, 0);
    contest("R9 plain rotation", 10'((1 << 1) | (1 << 2) | (1 << 4) | (1 << 7)), 4, e);
    apb_wr(31, 0, 1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_single();
    t_credit();
    t_funded();
    t_tie();
    t_urgent();
    t_mode();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule